// File: doc/BRIEF.md
# E1 Receive Overhead Bit Capture

This block watches the eight overhead bits that open every received E1 frame and presents them to a host in two forms at once. The first form is a per-double-frame snapshot: the full opening byte of an align frame and of the following non-align frame are held together. Both bytes move to the output registers at the start of the next align frame, and a sticky flag is raised. The host then has one double-frame, 250 µs, to read them.

The second form is a per-multiframe accumulation. Over one CRC-4 multiframe of 16 frames, the block collects the eight align-frame Si bits, the eight non-align-frame Si bits and eight samples each of Sa4 to Sa8. These appear at the next multiframe start with a second sticky flag, giving the host 2 ms per update. Each double-frame update also compares the new Sa bits with the previous ones and raises per-bit change status that the host can mask.

Framing is supplied from outside. The inputs are a serial bit with a strobe, a frame-start mark, an align/non-align indicator and a multiframe-start mark, all qualified by the bit strobe. Every frame must be longer than eight bit strobes.

Top module: `e1ovh_capture`

## Requirements
- R1: `dbl_align_byte` holds the first eight bits of the most recent complete align frame. The first bit received is bit 7 and the eighth bit is bit 0.
- R2: `dbl_nalign_byte` holds the first eight bits of a non-align frame in the same bit order. By convention bit 7 is Si, bit 6 is the fixed 1, bit 5 is the remote alarm bit, and bits 4 down to 0 are Sa4 down to Sa8.
- R3: A frame start with the align indicator high triggers a double-frame update, but only if an align byte and then a non-align byte have completed since the last update. Both bytes update on the clock edge after that strobe, and `dbl_flag` is set on the same edge. Without such a pair, nothing changes.
- R4: `dbl_flag`, `mf_flag` and each `sa_chg` bit stay set until their clear input is pulsed. A set and a clear in the same cycle leave the bit set.
- R5: `mf_si_align` holds the Si bit (byte bit 7) of the eight align frames of a multiframe. The first align frame's bit is the MSB.
- R6: `mf_si_nalign` holds the Si bits of the eight non-align frames of a multiframe, with the first frame in the MSB.
- R7: `mf_sa` holds one 8-bit lane for each Sa bit. Lane k, at bits [8k+7:8k], carries Sa(4+k), which is byte bit 4−k, of the eight non-align frames, with the first frame in the MSB.
- R8: On a multiframe-start strobe, the gathered multiframe values load on the next clock edge and `mf_flag` is set.
- R9: The multiframe registers load only if exactly eight align bytes and eight non-align bytes completed since the previous multiframe start (or since reset). Otherwise they keep their values, `mf_flag` is not set, and gathering restarts.
- R10: At every double-frame update except the first since reset, each Sa bit that differs from the previously published value and whose `sa_mask` bit is 0 sets its `sa_chg` bit. `sa_irq` is high on the same edge whenever any `sa_chg` bit is set.
- R11: After reset, every output is zero.
- R12: Bits after the eighth of a frame, and bits before the first frame start, have no effect on any capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received serial data bit |
| rx_bit_en | input | 1 | Bit strobe qualifying all rx_* inputs |
| rx_frm_start | input | 1 | Marks the first bit of a frame |
| rx_frm_align | input | 1 | High when the frame starting now is an align frame |
| rx_mf_start | input | 1 | Marks the first bit of a CRC-4 multiframe |
| sa_mask | input | 5 | Per-Sa change mask (1 = masked), index 0 is Sa4 |
| clr_dbl_flag | input | 1 | Clears dbl_flag |
| clr_mf_flag | input | 1 | Clears mf_flag |
| clr_sa_chg | input | 5 | Per-bit clear of sa_chg |
| dbl_align_byte | output | 8 | Latched align-frame overhead byte |
| dbl_nalign_byte | output | 8 | Latched non-align-frame overhead byte |
| dbl_flag | output | 1 | Sticky double-frame update flag |
| mf_si_align | output | 8 | Align-frame Si bits of the last multiframe |
| mf_si_nalign | output | 8 | Non-align-frame Si bits of the last multiframe |
| mf_sa | output | 40 | Sa4..Sa8 lanes of the last multiframe |
| mf_flag | output | 1 | Sticky multiframe update flag |
| sa_chg | output | 5 | Sticky Sa change status, index 0 is Sa4 |
| sa_irq | output | 1 | High while any sa_chg bit is set |

## Verification
The bench targets several corner cases. A short multiframe and a long one (15 and 17 frames) each follow a complete one. A design that published on any multiframe start would raise `mf_flag` and overwrite good data. Streams open with stray bits before the first frame and carry random tail bits in every frame, so a capture that ran past bit eight or started before framing would corrupt the bytes. The Sa masks change while Sa bits toggle, and clears fall at random, sometimes in the cycle of an update. A design that compared against the wrong byte, ignored the mask, reported a change at the very first update or let a clear win would diverge from the model on the next edge.

// File: rtl/e1ovh_pkg.sv
package e1ovh_pkg;
  localparam int TS_BITS = 8;   // overhead bits at the head of each frame
  localparam int NSA     = 5;   // Sa4..Sa8

  typedef struct packed {
    logic       vld;
    logic       align;
    logic [TS_BITS-1:0] dat;
  } ts0_byte_t;
endpackage

// File: rtl/e1ovh_ts0_shift.sv
module e1ovh_ts0_shift
  import e1ovh_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      bit_in,
  input  logic      bit_en,
  input  logic      frm_start,
  input  logic      frm_align,
  output ts0_byte_t byte_o
);
  localparam int IW = $clog2(TS_BITS + 1);
  localparam logic [IW-1:0] LAST = IW'(TS_BITS - 1);
  localparam logic [IW-1:0] IDLE = IW'(TS_BITS);

  logic [IW-1:0]        idx;
  logic [TS_BITS-2:0]   sh;
  logic                 cur_al;
  logic [IW-1:0]        pos;
  logic                 al_eff;

  always_comb begin
    pos    = frm_start ? '0 : idx;
    al_eff = frm_start ? frm_align : cur_al;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= IDLE;
      sh     <= '0;
      cur_al <= 1'b0;
      byte_o <= '0;
    end else begin
      byte_o.vld <= 1'b0;
      if (bit_en) begin
        cur_al <= al_eff;
        if (pos < IDLE) begin
          sh  <= {sh[TS_BITS-3:0], bit_in};
          idx <= pos + 1'b1;
          if (pos == LAST) begin
            byte_o.vld   <= 1'b1;
            byte_o.align <= al_eff;
            byte_o.dat   <= {sh, bit_in};
          end
        end else begin
          idx <= IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/e1ovh_dbl_latch.sv
module e1ovh_dbl_latch
  import e1ovh_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ts0_byte_t          byte_i,
  input  logic               pub_go,
  input  logic               clr_flag,
  input  logic [NSA-1:0]     sa_mask,
  input  logic [NSA-1:0]     clr_sa,
  output logic [TS_BITS-1:0] align_q,
  output logic [TS_BITS-1:0] nalign_q,
  output logic               flag,
  output logic [NSA-1:0]     sa_chg,
  output logic               sa_irq
);
  logic [TS_BITS-1:0] pend_a, pend_n;
  logic               have_a, have_pair, seen;
  logic               do_pub;
  logic [NSA-1:0]     new_sa, old_sa, chg_nxt;

  always_comb begin
    do_pub = pub_go && have_pair;
    for (int k = 0; k < NSA; k++) begin
      new_sa[k] = pend_n[NSA-1-k];
      old_sa[k] = nalign_q[NSA-1-k];
    end
    chg_nxt = sa_chg & ~clr_sa;
    if (do_pub && seen)
      chg_nxt = chg_nxt | ((new_sa ^ old_sa) & ~sa_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_a    <= '0;
      pend_n    <= '0;
      have_a    <= 1'b0;
      have_pair <= 1'b0;
      seen      <= 1'b0;
      align_q   <= '0;
      nalign_q  <= '0;
      flag      <= 1'b0;
      sa_chg    <= '0;
      sa_irq    <= 1'b0;
    end else begin
      if (byte_i.vld) begin
        if (byte_i.align) begin
          pend_a    <= byte_i.dat;
          have_a    <= 1'b1;
          have_pair <= 1'b0;
        end else begin
          pend_n <= byte_i.dat;
          if (have_a) have_pair <= 1'b1;
        end
      end else if (do_pub) begin
        have_a    <= 1'b0;
        have_pair <= 1'b0;
      end
      if (do_pub) begin
        align_q  <= pend_a;
        nalign_q <= pend_n;
        seen     <= 1'b1;
      end
      flag   <= do_pub | (flag & ~clr_flag);
      sa_chg <= chg_nxt;
      sa_irq <= |chg_nxt;
    end
  end
endmodule

// File: rtl/e1ovh_mf_accum.sv
module e1ovh_mf_accum
  import e1ovh_pkg::*;
#(
  parameter int HALF = 8
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                vld,
  input  logic                is_align,
  input  logic                si_bit,
  input  logic [NSA-1:0]      sa_bits,   // index 0 = Sa4
  input  logic                mf_go,
  input  logic                clr_flag,
  output logic [HALF-1:0]     si_a_q,
  output logic [HALF-1:0]     si_n_q,
  output logic [NSA*HALF-1:0] sa_q,
  output logic                flag
);
  localparam int CW = $clog2(HALF + 1) + 1;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] CFULL = CW'(HALF);

  logic [CW-1:0]   cnt_a, cnt_n;
  logic [HALF-1:0] sh_a, sh_n;
  logic            ok;

  assign ok = (cnt_a == CFULL) && (cnt_n == CFULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_a  <= '0;
      cnt_n  <= '0;
      sh_a   <= '0;
      sh_n   <= '0;
      si_a_q <= '0;
      si_n_q <= '0;
      flag   <= 1'b0;
    end else begin
      if (mf_go) begin
        if (ok) begin
          si_a_q <= sh_a;
          si_n_q <= sh_n;
        end
        cnt_a <= '0;
        cnt_n <= '0;
        sh_a  <= '0;
        sh_n  <= '0;
      end else if (vld) begin
        if (is_align) begin
          sh_a <= {sh_a[HALF-2:0], si_bit};
          if (cnt_a != CMAX) cnt_a <= cnt_a + 1'b1;
        end else begin
          sh_n <= {sh_n[HALF-2:0], si_bit};
          if (cnt_n != CMAX) cnt_n <= cnt_n + 1'b1;
        end
      end
      flag <= (mf_go & ok) | (flag & ~clr_flag);
    end
  end

  for (genvar k = 0; k < NSA; k++) begin : g_lane
    logic [HALF-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh                   <= '0;
        sa_q[k*HALF +: HALF] <= '0;
      end else if (mf_go) begin
        if (ok) sa_q[k*HALF +: HALF] <= sh;
        sh <= '0;
      end else if (vld && !is_align) begin
        sh <= {sh[HALF-2:0], sa_bits[k]};
      end
    end
  end
endmodule

// File: rtl/e1ovh_capture.sv
module e1ovh_capture
  import e1ovh_pkg::*;
#(
  parameter int MF_FRAMES = 16,
  localparam int HALF = MF_FRAMES / 2
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_bit,
  input  logic                rx_bit_en,
  input  logic                rx_frm_start,
  input  logic                rx_frm_align,
  input  logic                rx_mf_start,
  input  logic [NSA-1:0]      sa_mask,
  input  logic                clr_dbl_flag,
  input  logic                clr_mf_flag,
  input  logic [NSA-1:0]      clr_sa_chg,
  output logic [TS_BITS-1:0]  dbl_align_byte,
  output logic [TS_BITS-1:0]  dbl_nalign_byte,
  output logic                dbl_flag,
  output logic [HALF-1:0]     mf_si_align,
  output logic [HALF-1:0]     mf_si_nalign,
  output logic [NSA*HALF-1:0] mf_sa,
  output logic                mf_flag,
  output logic [NSA-1:0]      sa_chg,
  output logic                sa_irq
);
  ts0_byte_t      cap;
  logic           pub_go, mf_go;
  logic [NSA-1:0] sa_bits;

  assign pub_go = rx_bit_en & rx_frm_start & rx_frm_align;
  assign mf_go  = rx_bit_en & rx_frm_start & rx_mf_start;

  always_comb
    for (int k = 0; k < NSA; k++) sa_bits[k] = cap.dat[NSA-1-k];

  e1ovh_ts0_shift u_shift (
    .clk(clk), .rst(rst), .bit_in(rx_bit), .bit_en(rx_bit_en),
    .frm_start(rx_frm_start), .frm_align(rx_frm_align), .byte_o(cap)
  );

  e1ovh_dbl_latch u_dbl (
    .clk(clk), .rst(rst), .byte_i(cap), .pub_go(pub_go),
    .clr_flag(clr_dbl_flag), .sa_mask(sa_mask), .clr_sa(clr_sa_chg),
    .align_q(dbl_align_byte), .nalign_q(dbl_nalign_byte), .flag(dbl_flag),
    .sa_chg(sa_chg), .sa_irq(sa_irq)
  );

  e1ovh_mf_accum #(.HALF(HALF)) u_mf (
    .clk(clk), .rst(rst), .vld(cap.vld), .is_align(cap.align),
    .si_bit(cap.dat[TS_BITS-1]), .sa_bits(sa_bits), .mf_go(mf_go),
    .clr_flag(clr_mf_flag), .si_a_q(mf_si_align), .si_n_q(mf_si_nalign),
    .sa_q(mf_sa), .flag(mf_flag)
  );
endmodule

// File: rtl/e1ovh_capture_chk.sv
module e1ovh_capture_chk #(
  parameter int HALF = 8
)(
  input logic            clk,
  input logic            rst,
  input logic            rx_bit_en,
  input logic            rx_frm_start,
  input logic            rx_frm_align,
  input logic            rx_mf_start,
  input logic [4:0]      sa_mask,
  input logic            clr_dbl_flag,
  input logic [7:0]      dbl_align_byte,
  input logic            dbl_flag,
  input logic [HALF-1:0] mf_si_align,
  input logic            mf_flag,
  input logic [4:0]      sa_chg
);
  logic pub_go, mf_go;
  assign pub_go = rx_bit_en && rx_frm_start && rx_frm_align;
  assign mf_go  = rx_bit_en && rx_frm_start && rx_mf_start;

  // R3: the double-frame flag only rises right after an align-frame start
  a_r3_flag_after_align: assert property (@(posedge clk) disable iff (rst)
    $rose(dbl_flag) |-> $past(pub_go));

  // R1: captured align byte holds unless an align frame started
  a_r1_hold_between: assert property (@(posedge clk) disable iff (rst)
    !pub_go |=> $stable(dbl_align_byte));

  // R4: sticky until cleared
  a_r4_dbl_sticky: assert property (@(posedge clk) disable iff (rst)
    (dbl_flag && !clr_dbl_flag) |=> dbl_flag);

  // R8: multiframe flag only rises right after a multiframe start
  a_r8_mf_after_start: assert property (@(posedge clk) disable iff (rst)
    $rose(mf_flag) |-> $past(mf_go));

  // R5: multiframe register holds between multiframe starts
  a_r5_mf_hold: assert property (@(posedge clk) disable iff (rst)
    !mf_go |=> $stable(mf_si_align));

  // R10: a masked Sa bit never newly sets its change status
  a_r10_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    !(|(sa_chg & ~$past(sa_chg) & $past(sa_mask))));
endmodule

bind e1ovh_capture e1ovh_capture_chk #(.HALF(HALF)) u_chk (
  .clk(clk), .rst(rst), .rx_bit_en(rx_bit_en), .rx_frm_start(rx_frm_start),
  .rx_frm_align(rx_frm_align), .rx_mf_start(rx_mf_start), .sa_mask(sa_mask),
  .clr_dbl_flag(clr_dbl_flag), .dbl_align_byte(dbl_align_byte),
  .dbl_flag(dbl_flag), .mf_si_align(mf_si_align), .mf_flag(mf_flag),
  .sa_chg(sa_chg)
);

// File: tb/tb_e1ovh_capture.sv
`timescale 1ns/1ps
module tb_e1ovh_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_bit = 0, rx_bit_en = 0, rx_frm_start = 0, rx_frm_align = 0, rx_mf_start = 0;
  logic [4:0]  sa_mask = 0, clr_sa_chg = 0;
  logic        clr_dbl_flag = 0, clr_mf_flag = 0;
  logic [7:0]  dbl_align_byte, dbl_nalign_byte, mf_si_align, mf_si_nalign;
  logic [39:0] mf_sa;
  logic        dbl_flag, mf_flag, sa_irq;
  logic [4:0]  sa_chg;

  int n_tests = 0, n_fail = 0;
  bit done = 0, run_cmp = 0;

  always #2.5 clk = ~clk;

  e1ovh_capture dut (.*);

  // ---------------- behavioural reference ----------------
  bit         fb[$];
  logic [7:0] aq[$], nq[$];
  bit         m_al, m_in;
  int         m_pair;   // 0 none, 1 align seen, 2 align then non-align
  bit         m_seen;
  logic [7:0] m_pa, m_pn, m_a, m_n, m_sia, m_sin;
  logic [39:0] m_sa;
  bit         m_dflag, m_mflag, m_irq;
  logic [4:0] m_chg;

  always @(posedge clk) begin
    if (rst) begin
      fb.delete(); aq.delete(); nq.delete();
      m_al = 0; m_in = 0; m_pair = 0; m_seen = 0;
      m_pa = 0; m_pn = 0; m_a = 0; m_n = 0; m_sia = 0; m_sin = 0; m_sa = 0;
      m_dflag = 0; m_mflag = 0; m_irq = 0; m_chg = 0;
    end else begin
      bit dset, mset;
      logic [4:0] cset;
      dset = 0; mset = 0; cset = 0;
      if (rx_bit_en) begin
        if (rx_frm_start) begin
          if (rx_frm_align && m_pair == 2) begin
            if (m_seen)
              for (int k = 0; k < 5; k++)
                if (m_pn[4-k] != m_n[4-k] && !sa_mask[k]) cset[k] = 1;
            m_a = m_pa; m_n = m_pn; m_pair = 0; m_seen = 1; dset = 1;
          end
          if (rx_mf_start) begin
            if (aq.size() == 8 && nq.size() == 8) begin
              for (int i = 0; i < 8; i++) begin
                m_sia[7-i] = aq[i][7];
                m_sin[7-i] = nq[i][7];
                for (int k = 0; k < 5; k++) m_sa[k*8 + 7 - i] = nq[i][4-k];
              end
              mset = 1;
            end
            aq.delete(); nq.delete();
          end
          fb.delete(); m_al = rx_frm_align; m_in = 1;
        end
        if (m_in && fb.size() < 8) begin
          fb.push_back(rx_bit);
          if (fb.size() == 8) begin
            logic [7:0] b;
            for (int i = 0; i < 8; i++) b[7-i] = fb[i];
            if (m_al) begin aq.push_back(b); m_pa = b; m_pair = 1; end
            else begin nq.push_back(b); m_pn = b; if (m_pair >= 1) m_pair = 2; end
          end
        end
      end
      m_dflag = dset || (m_dflag && !clr_dbl_flag);
      m_mflag = mset || (m_mflag && !clr_mf_flag);
      m_chg   = cset | (m_chg & ~clr_sa_chg);
      m_irq   = |m_chg;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (run_cmp && !rst) begin
    chk("R1 align byte",      64'(dbl_align_byte),  64'(m_a));
    chk("R2 non-align byte",  64'(dbl_nalign_byte), 64'(m_n));
    chk("R3 dbl flag",        64'(dbl_flag),        64'(m_dflag));
    chk("R5 mf Si align",     64'(mf_si_align),     64'(m_sia));
    chk("R6 mf Si non-align", 64'(mf_si_nalign),    64'(m_sin));
    chk("R7 mf Sa lanes",     64'(mf_sa),           64'(m_sa));
    chk("R8 mf flag",         64'(mf_flag),         64'(m_mflag));
    chk("R10 sa change",      64'(sa_chg),          64'(m_chg));
    chk("R10 sa irq",         64'(sa_irq),          64'(m_irq));
  end

  // ---------------- stimulus ----------------
  task automatic strobe(bit b, bit fs, bit al, bit ms);
    if ($urandom_range(0, 3) == 0) begin
      rx_bit_en = 0; rx_frm_start = 0; rx_mf_start = 0;
      @(negedge clk);
    end
    rx_bit = b; rx_bit_en = 1; rx_frm_start = fs; rx_frm_align = al; rx_mf_start = ms;
    clr_dbl_flag = ($urandom_range(0, 29) == 0);
    clr_mf_flag  = ($urandom_range(0, 29) == 0);
    clr_sa_chg   = ($urandom_range(0, 9) == 0) ? 5'($urandom) : 5'd0;
    @(negedge clk);
    rx_bit_en = 0; rx_frm_start = 0; rx_mf_start = 0;
    clr_dbl_flag = 0; clr_mf_flag = 0; clr_sa_chg = 0;
  endtask

  task automatic frame(bit al, bit ms);
    logic [7:0] ts;
    ts = al ? {1'($urandom), 7'b0011011} : {1'($urandom), 1'b1, 6'($urandom)};
    for (int i = 0; i < 12; i++)
      strobe(i < 8 ? ts[7-i] : 1'($urandom), i == 0, al, ms && i == 0);
  endtask

  task automatic multiframe(int nfr);
    for (int f = 0; f < nfr; f++) begin
      if (f % 4 == 0) sa_mask = 5'($urandom);
      frame(f % 2 == 0, f == 0);
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11: reset state
    chk("R11 reset align",  64'(dbl_align_byte), 0);
    chk("R11 reset flags",  64'({dbl_flag, mf_flag, sa_irq, sa_chg}), 0);
    chk("R11 reset mf",     64'(mf_sa), 0);
    run_cmp = 1;
    // R12: bits before any frame start are ignored
    for (int i = 0; i < 20; i++) strobe(1'b1, 0, 1, 0);
    chk("R12 pre-frame bits", 64'({dbl_align_byte, dbl_nalign_byte}), 0);
    // partial first multiframe: six frames then a start
    for (int f = 0; f < 6; f++) frame(f % 2 == 0, 0);
    multiframe(16);
    // R9: the partial multiframe published nothing
    chk("R9 partial mf not published", 64'(mf_flag), 0);
    repeat (3) multiframe(16);
    multiframe(15);
    multiframe(16);
    multiframe(17);
    multiframe(16);
    repeat (2) multiframe(16);
    frame(1, 1);
    // R4: flag stays set with no clear, then clears
    clr_dbl_flag = 0; clr_mf_flag = 0;
    frame(0, 0); frame(1, 0);
    @(negedge clk);
    chk("R4 dbl flag sticky", 64'(dbl_flag), 64'(m_dflag));
    clr_dbl_flag = 1; @(negedge clk); clr_dbl_flag = 0; @(negedge clk);
    chk("R4 dbl flag cleared", 64'(dbl_flag), 0);
    clr_mf_flag = 1; @(negedge clk); clr_mf_flag = 0; @(negedge clk);
    chk("R4 mf flag cleared", 64'(mf_flag), 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule